// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a bank of general-purpose I/O lines controlled through a simple register bus. Each bus access takes one cycle: an address with a write strobe and write data, or an address with a read strobe. All registers are as wide as the bus word, and that width also sets the number of lines. Each line has an output value and an output enable for the pad logic, and a pin input that is synchronised before software can read it.

Software drives lines without a read-modify-write sequence. It writes ones to a set register to raise lines and ones to a clear register to lower them. The zero bits in such a write leave their lines alone. Line direction can be written in either polarity through two registers that always read back as complements of each other. Two elaboration-time options change how the bus word relates to the lines. One mirrors the bit order so that the highest bit addresses line 0. The other reverses the byte order of the word.

Top module: `mmgpio_ctrl`

## Requirements
- R1: After reset every output value and output enable is 0, the output-direction register (offset 3) reads 0 and the input-direction register (offset 4) reads all ones.
- R2: A read of offset 0 returns the pin levels after a two-stage synchroniser, with 1 meaning the line is high. A write to offset 0 has no effect.
- R3: A write to offset 1 raises every line whose bit is 1 and leaves the other lines unchanged. The new output values appear at the clock edge that ends the write cycle. Outputs change on no other access.
- R4: A write to offset 2 lowers every line whose bit is 1 and leaves the other lines unchanged. The new output values appear at the clock edge that ends the write cycle.
- R5: A write to offset 3 loads the direction of each line, where 1 means output. The output enables follow at the edge that ends the write cycle.
- R6: A write to offset 4 loads the direction of each line, where 1 means input. Each output enable becomes the inverse of the written bit.
- R7: Offsets 3 and 4 always read back as bitwise complements of each other, whichever of the two was last written.
- R8: A read of offset 1 or offset 2 returns the latched output values, not the pin levels.
- R9: With MIRROR set, line n corresponds to bus bit W-1-n in every register, for both reads and writes.
- R10: With BYTE_SWAP set, the bus word is the line-order word with its bytes reversed, for both reads and writes. Setting BYTE_SWAP together with a 64-bit width is rejected at elaboration.
- R11: Read data is registered and is valid on the cycle after the read strobe. It holds its value while the read strobe is low. Offsets 5 to 7 read 0, and writes to them change nothing.
- R12: The output latch keeps its value and stays visible on the output pins while lines are configured as inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released in step with the clock |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | W | Write data |
| rd_en | input | 1 | Read strobe for one cycle |
| rdata | output | W | Registered read data |
| gpio_i | input | W | Pin input levels (asynchronous) |
| gpio_o | output | W | Output value for each line |
| gpio_oe | output | W | Output enable for each line, 1 meaning drive |

## Verification
A write to the set, clear or either direction register is due on gpio_o or gpio_oe at the rising edge that closes the write cycle. The bench checks these at the falling edge that follows. Read data is due one edge after the read strobe. A pin change needs two edges in the synchroniser before the edge that captures it into read data. A behavioural model in the bench advances on the same edges, using a two-entry queue for the synchroniser. Its gpio_o, gpio_oe and rdata are compared with the design at every falling edge, so a result that arrives one cycle early or late is reported. Separate directed checks at falling edges cover the mirrored and byte-swapped instances.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register offsets; the bus decoder and the bench depend on these values.
  localparam int OFS_PINS   = 0;
  localparam int OFS_SET    = 1;
  localparam int OFS_CLR    = 2;
  localparam int OFS_DIROUT = 3;
  localparam int OFS_DIRIN  = 4;

  // One write strobe per writable register, decoded once in the top.
  typedef struct packed {
    logic set;
    logic clr;
    logic dout;
    logic din;
  } wr_strobe_t;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/gpio_bus_xform.sv
// Bit permutation between bus order and line order. Mirroring and byte
// reversal are each their own inverse and commute, so one instance serves
// the write path and another the read path.
module gpio_bus_xform #(
  parameter int W         = 32,
  parameter bit MIRROR    = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int NBYTE = W / 8;

  logic [W-1:0] mir;

  generate
    if (MIRROR) begin : g_mirror
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign mir[i] = din[W-1-i];
      end
    end else begin : g_straight
      assign mir = din;
    end

    if (BYTE_SWAP) begin : g_swap
      for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        assign dout[8*k +: 8] = mir[8*(NBYTE-1-k) +: 8];
      end
    end else begin : g_noswap
      assign dout = mir;
    end
  endgenerate

endmodule

// File: rtl/gpio_line_regs.sv
// Output latch and direction state, both kept in line order.
module gpio_line_regs
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_strobe_t   stb,
  input  logic [W-1:0] wline,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q
);

  logic [W-1:0] out_d;
  logic [W-1:0] dir_d;
  logic         out_en;
  logic         dir_en;

  always_comb begin
    out_en = stb.set | stb.clr;
    out_d  = out_q;
    if (stb.set) out_d = out_q | wline;
    if (stb.clr) out_d = out_q & ~wline;
  end

  always_comb begin
    dir_en = stb.dout | stb.din;
    dir_d  = dir_q;
    if (stb.dout) dir_d = wline;
    if (stb.din)  dir_d = ~wline;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/mmgpio_ctrl.sv
module mmgpio_ctrl
  import gpio_pkg::*;
#(
  parameter int W         = 32,
  parameter int ADDR_W    = 3,
  parameter bit MIRROR    = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wdata,
  input  logic              rd_en,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      gpio_i,
  output logic [W-1:0]      gpio_o,
  output logic [W-1:0]      gpio_oe
);

  localparam logic [ADDR_W-1:0] A_PINS   = ADDR_W'(OFS_PINS);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_DIROUT = ADDR_W'(OFS_DIROUT);
  localparam logic [ADDR_W-1:0] A_DIRIN  = ADDR_W'(OFS_DIRIN);

  generate
    if (W != 8 && W != 16 && W != 32 && W != 64) begin : g_bad_width
      $error("mmgpio_ctrl: W must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && W == 64) begin : g_bad_swap
      $error("mmgpio_ctrl: byte swap is not allowed at 64 bits");
    end
  endgenerate

  logic [W-1:0] wr_line;
  logic [W-1:0] pin_sync;
  logic [W-1:0] out_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] rd_line;
  logic [W-1:0] rd_bus;
  logic [W-1:0] rdata_d;
  logic [W-1:0] rdata_q;
  wr_strobe_t   stb;

  gpio_bus_xform #(.W(W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_wr_xform (
    .din  (wdata),
    .dout (wr_line)
  );

  // Write decode; offset 0 and unmapped offsets produce no strobe.
  always_comb begin
    stb.set  = wr_en && (addr == A_SET);
    stb.clr  = wr_en && (addr == A_CLR);
    stb.dout = wr_en && (addr == A_DIROUT);
    stb.din  = wr_en && (addr == A_DIRIN);
  end

  gpio_line_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (stb),
    .wline (wr_line),
    .out_q (out_q),
    .dir_q (dir_q)
  );

  gpio_sync2 #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (gpio_i),
    .q     (pin_sync)
  );

  always_comb begin
    case (addr)
      A_PINS:        rd_line = pin_sync;
      A_SET, A_CLR:  rd_line = out_q;
      A_DIROUT:      rd_line = dir_q;
      A_DIRIN:       rd_line = ~dir_q;
      default:       rd_line = '0;
    endcase
  end

  gpio_bus_xform #(.W(W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_rd_xform (
    .din  (rd_line),
    .dout (rd_bus)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign gpio_o  = out_q;
  assign gpio_oe = dir_q;

endmodule

// File: rtl/mmgpio_ctrl_chk.sv
module mmgpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [W-1:0]      wline,
  input logic [W-1:0]      gpio_o,
  input logic [W-1:0]      gpio_oe,
  input logic [W-1:0]      rdata
);

  localparam logic [ADDR_W-1:0] C_SET    = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] C_CLR    = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] C_DIROUT = ADDR_W'(OFS_DIROUT);
  localparam logic [ADDR_W-1:0] C_DIRIN  = ADDR_W'(OFS_DIRIN);

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_SET) |=> ((gpio_o & $past(wline)) == $past(wline))); // R3

  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_SET) |=>
      ((gpio_o & ~$past(wline)) == ($past(gpio_o) & ~$past(wline)))); // R3

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == C_SET || addr == C_CLR)) |=> $stable(gpio_o)); // R3

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_CLR) |=> ((gpio_o & $past(wline)) == '0)); // R4

  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_CLR) |=>
      ((gpio_o & ~$past(wline)) == ($past(gpio_o) & ~$past(wline)))); // R4

  AST_DIROUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_DIROUT) |=> (gpio_oe == $past(wline))); // R5

  AST_DIRIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_DIRIN) |=> (gpio_oe == ~$past(wline))); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R11

endmodule

bind mmgpio_ctrl mmgpio_ctrl_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .wline   (wr_line),
  .gpio_o  (gpio_o),
  .gpio_oe (gpio_oe),
  .rdata   (rdata)
);

// File: tb/tb_mmgpio_ctrl.sv
module tb_mmgpio_ctrl;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [2:0]  addr;
  logic        wr_en, rd_en;
  logic [15:0] wd16, pins16, o16, oe16, rd16;
  logic [7:0]  wd8, pins8, o8, oe8, rd8;
  logic [31:0] wd32, pins32, o32, oe32, rd32;
  logic        cmp_on;
  int          checks = 0;
  int          errors = 0;

  mmgpio_ctrl #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wd16),
    .rd_en(rd_en), .rdata(rd16), .gpio_i(pins16), .gpio_o(o16), .gpio_oe(oe16));

  mmgpio_ctrl #(.W(8), .MIRROR(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wd8),
    .rd_en(rd_en), .rdata(rd8), .gpio_i(pins8), .gpio_o(o8), .gpio_oe(oe8));

  mmgpio_ctrl #(.W(32), .BYTE_SWAP(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wd32),
    .rd_en(rd_en), .rdata(rd32), .gpio_i(pins32), .gpio_o(o32), .gpio_oe(oe32));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural reference for the 16-bit instance.
  logic [15:0] m_out, m_dir, m_rd;
  logic [15:0] m_pipe[$];
  string       m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_rd = '0;
      m_pipe = {16'h0, 16'h0};
      m_tag = "R1";
    end else begin
      if (rd_en) begin
        case (addr)
          3'd0:       begin m_rd = m_pipe[0]; m_tag = "R2";  end
          3'd1, 3'd2: begin m_rd = m_out;     m_tag = "R8";  end
          3'd3:       begin m_rd = m_dir;     m_tag = "R7";  end
          3'd4:       begin m_rd = ~m_dir;    m_tag = "R7";  end
          default:    begin m_rd = '0;        m_tag = "R11"; end
        endcase
      end
      if (wr_en) begin
        case (addr)
          3'd1: m_out = m_out | wd16;
          3'd2: m_out = m_out & ~wd16;
          3'd3: m_dir = wd16;
          3'd4: m_dir = ~wd16;
          default: ;
        endcase
      end
      void'(m_pipe.pop_front());
      m_pipe.push_back(pins16);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 gpio_o vs model", o16, m_out);
      chk("R5 gpio_oe vs model", oe16, m_dir);
      chk({m_tag, " rdata vs model"}, rd16, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d16,
                    input logic [7:0] d8, input logic [31:0] d32);
    addr = a; wd16 = d16; wd8 = d8; wd32 = d32; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0;
    wd16 = '0; wd8 = '0; wd32 = '0; pins16 = '0; pins8 = '0; pins32 = '0;
    cmp_on = 1'b0;
    idle(3);
    cmp_on = 1'b1;
    chk("R1 reset gpio_o", o16, 16'h0);
    chk("R1 reset gpio_oe", oe16, 16'h0);
    rst_n = 1'b1;
    idle(1);
    rd(3'd4); chk("R1 input-direction reads ones", rd16, 16'hFFFF);
    rd(3'd3); chk("R1 output-direction reads zero", rd16, 16'h0000);

    wr(3'd1, 16'h00F0, 8'h0, 32'h0); chk("R3 set raises", o16, 16'h00F0);
    wr(3'd1, 16'h0003, 8'h0, 32'h0); chk("R3 zeros keep", o16, 16'h00F3);
    wr(3'd2, 16'h0030, 8'h0, 32'h0); chk("R4 clear lowers", o16, 16'h00C3);
    wr(3'd0, 16'hFFFF, 8'h0, 32'h0); chk("R2 data write ignored", o16, 16'h00C3);
    rd(3'd1); chk("R8 set reads latch", rd16, 16'h00C3);
    rd(3'd2); chk("R8 clear reads latch", rd16, 16'h00C3);

    wr(3'd3, 16'hFF00, 8'h0, 32'h0); chk("R5 dirout sets enables", oe16, 16'hFF00);
    rd(3'd4); chk("R7 complement after dirout", rd16, 16'h00FF);
    wr(3'd4, 16'h0F0F, 8'h0, 32'h0); chk("R6 dirin inverts", oe16, 16'hF0F0);
    rd(3'd3); chk("R7 complement after dirin", rd16, 16'hF0F0);

    pins16 = 16'hA5C3;
    rd(3'd0);
    idle(3);
    rd(3'd0); chk("R2 pin levels", rd16, 16'hA5C3);
    pins16 = 16'h1234;
    idle(4); chk("R11 rdata holds", rd16, 16'hA5C3);

    wr(3'd7, 16'hFFFF, 8'h0, 32'h0); chk("R11 unmapped write ignored", o16, 16'h00C3);
    rd(3'd7); chk("R11 unmapped reads zero", rd16, 16'h0000);

    wr(3'd3, 16'h0000, 8'h0, 32'h0);
    wr(3'd1, 16'hFFFF, 8'h0, 32'h0);
    chk("R12 latch visible while input", o16, 16'hFFFF);
    chk("R12 enables stay off", oe16, 16'h0000);

    wr(3'd1, 16'h0, 8'h01, 32'h0); chk("R9 bus bit0 is line7", o8, 8'h80);
    wr(3'd3, 16'h0, 8'h02, 32'h0); chk("R9 direction mirrored", oe8, 8'h40);
    pins8 = 8'h02;
    idle(3);
    rd(3'd0); chk("R9 pins mirrored", rd8, 8'h40);
    rd(3'd1); chk("R9 latch reads mirrored", rd8, 8'h01);

    wr(3'd1, 16'h0, 8'h0, 32'h11223344); chk("R10 bytes reversed", o32, 32'h44332211);
    rd(3'd1); chk("R10 read reversed back", rd32, 32'h11223344);
    pins32 = 32'hA1B2C3D4;
    idle(3);
    rd(3'd0); chk("R10 pins reversed", rd32, 32'hD4C3B2A1);
    wr(3'd2, 16'h0, 8'h0, 32'h00000044); chk("R10 clear swapped", o32, 32'h00332211);

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule